// File: doc/BRIEF.md
# Serial Flash Page Program Buffer

This block is the page-program data path of a serial flash slave. While chip select is low it decodes a command byte sent one bit per clock on data line 0, then collects a 24-bit address and a stream of data bytes into a page buffer. Two program commands are accepted. One carries address and data one bit per serial clock. The other carries them four bits per serial clock. All serial inputs are synchronised into the system clock domain, and the block acts on rising serial-clock edges.

When chip select rises after a well-formed frame, the block commits the buffered bytes to the array through a byte-wide port. It reads each old array byte, ANDs it with the new byte and writes the result back. The commit is allowed only if the write-enable latch is set and the external protection input is low. Data that run past the end of the page wrap to the start of the same page, so only the last page-worth of bytes is kept. A busy flag covers the commit walk. Frames that begin while the block is busy are ignored.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `busy`, `welOut` and `arrWrEn` are all 0.
- R2: Command 0x02 takes the address (24 bits) and then the data bytes one bit per rising `spiSck` on `spiIo[0]`, most significant bit first. Byte k is programmed at column (address[7:0] + k) of the page.
- R3: Command 0x38 takes the command byte on `spiIo[0]`. It then takes address and data four bits per rising `spiSck` on `spiIo[3:0]`, with `spiIo[3]` as the most significant bit and the high nibble of each byte first.
- R4: The column advances modulo 256 and never carries into the page. Every write of a commit goes to page address[23:8].
- R5: When more than 256 data bytes are sent, only the last 256 are programmed.
- R6: Each programmed array byte becomes old AND new. Array bytes at columns that received no data are left unchanged.
- R7: A `weSet` pulse while not busy sets `welOut`. Without `welOut` set, a frame writes nothing.
- R8: A frame is dropped, with no write and `welOut` kept, when chip select rises with a partial data byte or with no data byte.
- R9: A committed frame raises `busy` within a few cycles of chip select rising. All array writes happen while `busy` is high, and `welOut` clears when `busy` falls.
- R10: A well-formed frame with `welOut` set and `protect` high at chip-select rise writes nothing and clears `welOut`.
- R11: A frame whose chip select falls while `busy` is high is ignored. A frame with any other command code is ignored. In both cases `welOut` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Serial chip select, active low |
| spiSck | input | 1 | Serial clock; data sampled on its rising edge |
| spiIo | input | 4 | Serial data lines; line 0 alone in one-bit mode |
| weSet | input | 1 | One-cycle pulse that sets the write-enable latch |
| protect | input | 1 | Target page protected; sampled at chip-select rise |
| arrRdData | input | 8 | Current array byte at `arrAddr` (combinational read) |
| busy | output | 1 | Commit in progress |
| welOut | output | 1 | Write-enable latch state |
| arrAddr | output | 24 | Array byte address during commit |
| arrWrData | output | 8 | Byte to write (old AND new) |
| arrWrEn | output | 1 | Array write strobe |

## Verification
Serial inputs pass through two synchroniser flops and one edge-detect flop. The bench therefore holds every serial level for four system clocks on each side of an edge. Chip select rises four clocks after the last serial edge. `busy` is due within four cycles of that rise, and the bench samples it six cycles after the rise. A commit walks every column, so it takes about 256 cycles. The bench polls `busy` at falling clock edges, and only after it drops does it compare the whole array model and `welOut` against values computed from the frame's address, length and data pattern.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } frameState_t;

  typedef struct packed {
    logic frameStart;
    logic addrShift;
    logic dataShift;
    logic storeByte;
    logic quad;
    logic commitStart;
  } ppStrobe_t;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pp_control.sv
module pp_control
  import pp_pkg::*;
#(
  parameter logic [7:0] CMD_SINGLE = 8'h02,
  parameter logic [7:0] CMD_QUAD   = 8'h38,
  parameter int ADDR_BITS = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      sckS,
  input  logic      io0,
  input  logic      weSet,
  input  logic      protect,
  input  logic      commitDone,
  output ppStrobe_t strb,
  output logic      busy,
  output logic      wel
);
  localparam int CNT_W = $clog2(ADDR_BITS + 1);

  frameState_t state;
  logic csPrev, sckPrev;
  logic [7:0] cmdSh;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitPos;
  logic gotByte, quad;

  logic sckRise, csFall, csRise, wellFormed;
  logic [7:0] cmdNext;
  logic [CNT_W-1:0] addrStep;
  logic [2:0] bitStep;

  assign sckRise  = sckS & ~sckPrev & ~csS;
  assign csFall   = ~csS & csPrev;
  assign csRise   = csS & ~csPrev;
  assign cmdNext  = {cmdSh[6:0], io0};
  assign addrStep = quad ? CNT_W'(4) : CNT_W'(1);
  assign bitStep  = quad ? 3'd4 : 3'd1;
  assign wellFormed = (state == ST_DATA) && (bitPos == 3'd0) && gotByte;

  always_comb begin
    strb = '0;
    strb.quad        = quad;
    strb.frameStart  = (state == ST_IDLE) && csFall && !busy;
    strb.addrShift   = (state == ST_ADDR) && sckRise;
    strb.dataShift   = (state == ST_DATA) && sckRise;
    strb.storeByte   = strb.dataShift && ((bitPos + bitStep) == 3'd0);
    strb.commitStart = csRise && wellFormed && wel && !protect && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdSh   <= '0;
      cnt     <= '0;
      bitPos  <= '0;
      gotByte <= 1'b0;
      quad    <= 1'b0;
    end else if (csRise) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (csFall) begin
          state   <= busy ? ST_SKIP : ST_CMD;
          cnt     <= '0;
          bitPos  <= '0;
          gotByte <= 1'b0;
          quad    <= 1'b0;
        end
        ST_CMD: if (sckRise) begin
          cmdSh <= cmdNext;
          cnt   <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (cmdNext == CMD_SINGLE) begin
              state <= ST_ADDR;
              quad  <= 1'b0;
            end else if (cmdNext == CMD_QUAD) begin
              state <= ST_ADDR;
              quad  <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADDR: if (sckRise) begin
          cnt <= cnt + addrStep;
          if ((cnt + addrStep) == CNT_W'(ADDR_BITS)) state <= ST_DATA;
        end
        ST_DATA: if (sckRise) begin
          bitPos <= bitPos + bitStep;
          if (strb.storeByte) gotByte <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      wel  <= 1'b0;
    end else begin
      if (strb.commitStart) busy <= 1'b1;
      else if (commitDone) busy <= 1'b0;

      if (commitDone) wel <= 1'b0;
      else if (csRise && wellFormed && wel && protect && !busy) wel <= 1'b0;
      else if (weSet && !busy) wel <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BITS  = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ppStrobe_t            strb,
  input  logic [3:0]           io,
  input  logic [7:0]           arrRdData,
  output logic [ADDR_BITS-1:0] arrAddr,
  output logic [7:0]           arrWrData,
  output logic                 arrWrEn,
  output logic                 commitDone
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic [ADDR_BITS-1:0] addrReg;
  logic [7:0] shReg, nextSh;
  logic [COL_W-1:0] colOff, storeCol, walkIdx;
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validBits;
  logic walking;

  assign nextSh   = strb.quad ? {shReg[3:0], io} : {shReg[6:0], io[0]};
  assign storeCol = addrReg[COL_W-1:0] + colOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      shReg   <= '0;
      colOff  <= '0;
    end else begin
      if (strb.frameStart) begin
        addrReg <= '0;
        colOff  <= '0;
      end else if (strb.addrShift) begin
        addrReg <= strb.quad ? {addrReg[ADDR_BITS-5:0], io}
                             : {addrReg[ADDR_BITS-2:0], io[0]};
      end
      if (strb.dataShift) shReg <= nextSh;
      if (strb.storeByte) colOff <= colOff + COL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeByte) pageBuf[storeCol] <= nextSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strb.frameStart) begin
      validBits <= '0;
    end else if (strb.storeByte) begin
      validBits[storeCol] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walking <= 1'b0;
      walkIdx <= '0;
    end else if (strb.commitStart) begin
      walking <= 1'b1;
      walkIdx <= '0;
    end else if (walking) begin
      walkIdx <= walkIdx + COL_W'(1);
      if (walkIdx == LAST_COL) walking <= 1'b0;
    end
  end

  assign commitDone = walking && (walkIdx == LAST_COL);
  assign arrWrEn    = walking && validBits[walkIdx];
  assign arrAddr    = {addrReg[ADDR_BITS-1:COL_W], walkIdx};
  assign arrWrData  = arrRdData & pageBuf[walkIdx];
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BITS  = 24,
  parameter logic [7:0] CMD_SINGLE = 8'h02,
  parameter logic [7:0] CMD_QUAD   = 8'h38
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiCsN,
  input  logic                 spiSck,
  input  logic [3:0]           spiIo,
  input  logic                 weSet,
  input  logic                 protect,
  input  logic [7:0]           arrRdData,
  output logic                 busy,
  output logic                 welOut,
  output logic [ADDR_BITS-1:0] arrAddr,
  output logic [7:0]           arrWrData,
  output logic                 arrWrEn
);
  logic [5:0] syncQ;
  ppStrobe_t strb;
  logic commitDone;

  pp_sync #(.W(6), .STAGES(2), .RST_VAL(6'b100000)) sync_i (
    .clk(clk), .rstN(rstN),
    .d({spiCsN, spiSck, spiIo}),
    .q(syncQ)
  );

  pp_control #(.CMD_SINGLE(CMD_SINGLE), .CMD_QUAD(CMD_QUAD), .ADDR_BITS(ADDR_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .csS(syncQ[5]), .sckS(syncQ[4]), .io0(syncQ[0]),
    .weSet(weSet), .protect(protect), .commitDone(commitDone),
    .strb(strb), .busy(busy), .wel(welOut)
  );

  pp_datapath #(.PAGE_BYTES(PAGE_BYTES), .ADDR_BITS(ADDR_BITS)) dp_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .io(syncQ[3:0]), .arrRdData(arrRdData),
    .arrAddr(arrAddr), .arrWrData(arrWrData), .arrWrEn(arrWrEn),
    .commitDone(commitDone)
  );
endmodule

// File: rtl/flash_page_prog_chk.sv
module flash_page_prog_chk #(
  parameter int ADDR_BITS = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 welOut,
  input logic [ADDR_BITS-1:0] arrAddr,
  input logic [7:0]           arrWrData,
  input logic [7:0]           arrRdData,
  input logic                 arrWrEn
);
  AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy); // R9

  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !welOut); // R9

  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(welOut)); // R7

  AST_PAGE_BASE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |-> (arrAddr[ADDR_BITS-1:8] == $past(arrAddr[ADDR_BITS-1:8]))); // R4

  AST_ONLY_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> ((arrWrData & ~arrRdData) == 8'h00)); // R6
endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_BITS(ADDR_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .welOut(welOut),
  .arrAddr(arrAddr), .arrWrData(arrWrData), .arrRdData(arrRdData), .arrWrEn(arrWrEn)
);

// File: tb/flash_page_prog_tb_top.sv
`timescale 1ns/1ps
module flash_page_prog_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSck = 1'b0, weSet = 1'b0, protect = 1'b0;
  logic [3:0] spiIo = '0;
  logic [7:0] arrRdData, arrWrData;
  logic [23:0] arrAddr;
  logic busy, welOut, arrWrEn;

  logic [7:0] mem [1024];
  logic [7:0] expMem [1024];
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  flash_page_prog dut_i (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiIo(spiIo),
    .weSet(weSet), .protect(protect), .arrRdData(arrRdData),
    .busy(busy), .welOut(welOut), .arrAddr(arrAddr), .arrWrData(arrWrData), .arrWrEn(arrWrEn)
  );

  assign arrRdData = mem[arrAddr[9:0]];
  always @(posedge clk) if (arrWrEn) mem[arrAddr[9:0]] <= arrWrData;

  function automatic logic [7:0] dataOf(int seed, int k);
    return 8'((k * 29 + seed * 71 + 3) ^ (k >> 3));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic unitOut(input logic [3:0] v);
    @(negedge clk) spiIo = v;
    repeat (4) @(negedge clk);
    spiSck = 1'b1;
    repeat (4) @(negedge clk);
    spiSck = 1'b0;
  endtask

  task automatic frame(input bit quad, input logic [7:0] cmd, input logic [23:0] addr,
                       input int nBytes, input int extraBits, input int seed);
    @(negedge clk) spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) unitOut({3'b000, cmd[i]});
    if (quad) for (int i = 5; i >= 0; i--) unitOut(addr[i*4 +: 4]);
    else for (int i = 23; i >= 0; i--) unitOut({3'b000, addr[i]});
    for (int k = 0; k < nBytes; k++) begin
      logic [7:0] b;
      b = dataOf(seed, k);
      if (quad) begin unitOut(b[7:4]); unitOut(b[3:0]); end
      else for (int i = 7; i >= 0; i--) unitOut({3'b000, b[i]});
    end
    for (int e = 0; e < extraBits; e++) unitOut(4'b1010);
    repeat (4) @(negedge clk);
    spiCsN = 1'b1;
  endtask

  task automatic expCommit(input logic [23:0] addr, input int nBytes, input int seed);
    logic [7:0] buffer [256];
    bit valid [256];
    for (int c = 0; c < 256; c++) valid[c] = 0;
    for (int k = 0; k < nBytes; k++) begin
      int col;
      col = (int'(addr[7:0]) + k) % 256;
      buffer[col] = dataOf(seed, k);
      valid[col] = 1;
    end
    for (int c = 0; c < 256; c++)
      if (valid[c]) expMem[{addr[9:8], 8'(c)}] &= buffer[c];
  endtask

  task automatic pulseWe();
    @(negedge clk) weSet = 1'b1;
    @(negedge clk) weSet = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (10) @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic checkArray(input string req, input string what);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expMem[i]) bad++;
    chk(req, what, bad, 0);
  endtask

  task automatic progFrame(input string req, input bit quad, input logic [23:0] addr,
                           input int nBytes, input int seed);
    pulseWe();
    chk("R7", "wel set by pulse", int'(welOut), 1);
    frame(quad, quad ? 8'h38 : 8'h02, addr, nBytes, 0, seed);
    repeat (6) @(negedge clk);
    chk("R9", "busy after commit start", int'(busy), 1);
    expCommit(addr, nBytes, seed);
    waitIdle();
    checkArray(req, "array after program");
    chk("R9", "wel cleared after commit", int'(welOut), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'hFF;
      expMem[i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "wel after reset", int'(welOut), 0);
    chk("R1", "write strobe after reset", int'(arrWrEn), 0);

    progFrame("R2", 1'b0, 24'h000010, 5, 1);
    progFrame("R3", 1'b1, 24'h000120, 6, 2);
    for (int m = 0; m < 2; m++)
      for (int len = 1; len <= 3; len++)
        progFrame(m ? "R3" : "R2", m[0], 24'(32'h140 + m * 32'h40 + len * 8), len, 10 + len);
    progFrame("R4", 1'b0, 24'h0002FC, 8, 3);
    progFrame("R5", 1'b1, 24'h000305, 300, 4);
    progFrame("R6", 1'b0, 24'h000010, 5, 9);

    frame(1'b0, 8'h02, 24'h000200, 3, 0, 5);
    waitIdle();
    checkArray("R7", "no write without wel");

    pulseWe();
    frame(1'b1, 8'h38, 24'h000040, 2, 1, 6);
    waitIdle();
    checkArray("R8", "partial quad byte dropped");
    chk("R8", "wel kept after drop", int'(welOut), 1);
    frame(1'b0, 8'h02, 24'h000050, 1, 3, 7);
    waitIdle();
    checkArray("R8", "partial single byte dropped");
    frame(1'b0, 8'h02, 24'h000060, 0, 0, 7);
    waitIdle();
    checkArray("R8", "zero data bytes dropped");
    chk("R8", "wel kept after empty frame", int'(welOut), 1);

    frame(1'b0, 8'h02, 24'h000080, 2, 0, 8);
    expCommit(24'h000080, 2, 8);
    repeat (6) @(negedge clk);
    chk("R9", "busy for overlap test", int'(busy), 1);
    fork
      frame(1'b0, 8'h02, 24'h000090, 3, 0, 12);
      begin repeat (400) @(negedge clk); pulseWe(); end
    join
    waitIdle();
    checkArray("R11", "frame started while busy ignored");
    chk("R11", "wel kept after busy-ignored frame", int'(welOut), 1);

    frame(1'b0, 8'h03, 24'h0000A0, 2, 0, 13);
    waitIdle();
    checkArray("R11", "other command ignored");
    chk("R11", "wel kept after other command", int'(welOut), 1);

    protect = 1'b1;
    frame(1'b0, 8'h02, 24'h0000B0, 2, 0, 14);
    waitIdle();
    protect = 1'b0;
    checkArray("R10", "protected frame writes nothing");
    chk("R10", "wel cleared by protected frame", int'(welOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule